// File: doc/BRIEF.md
# Mutual Clock-Loss Monitor

This block lets a fast system clock (32 MHz by default) and a slow always-on clock (32 kHz by default) check each other. Each clock domain holds an activity watchdog for the opposite clock. The fast watchdog counts fast cycles between rising edges of the slow clock, after those edges pass through a synchronizer. The slow watchdog counts slow cycles between changes of a beacon flag that the fast domain toggles at a divided rate. When either count reaches its limit, a sticky reset request is raised. It stays raised until the asynchronous power-on reset clears the block.

Software sets one enable bit in an 8-bit control register to turn monitoring on. A pause input from the power-mode logic suspends both watchdogs while the clocks may legally stop. After an enable or a resume, both counters stay cleared for a short settle window, so stale edge history cannot cause a false loss.

The block also keeps a 2-bit record of the last reset cause, which is read after the next boot. Only power-on clears this record. Brownout, external-pin, watchdog and clock-loss events overwrite it on the cycle they occur. A brownout writes the same code as power-on.

Top module: `clkloss_monitor`

## Requirements
- R1: The control readback `reg_rdata_o` is 8 bits wide. Bit 0 is the enable. It is 0 after power-on reset and takes `reg_wdata_i[0]` on each fast cycle where `reg_wr_i` is high. Bits 7:1 always read 0, whatever was written to them.
- R2: While the block is enabled and not paused, and both clocks keep running, `rst_req_o` stays 0.
- R3: If the slow clock stops while monitoring is active, `rst_req_o` rises between FAST_LIMIT and FAST_LIMIT+4 fast cycles after the last rising edge of the slow clock.
- R4: If the fast clock stops while monitoring is active, `rst_req_o` rises no later than SLOW_LIMIT+4 slow cycles after the last edge of the fast clock. It is still 0 two slow cycles after that edge.
- R5: Once `rst_req_o` is 1, it stays 1 until `por_n` goes low. Clearing the enable does not drop it.
- R6: While the enable bit is 0, stopping either clock never raises `rst_req_o`.
- R7: While `pause_i` is high, stopping either clock never raises `rst_req_o`. After `pause_i` falls with both clocks running, no request appears, and a later clock stop is detected again as in R3.
- R8: `cause_o` uses these codes: 00 for power-on or brownout, 01 for external pin, 10 for watchdog, 11 for clock loss. `por_n` low forces 00. A clock loss writes 11 on the fast cycle where the loss first becomes visible in the fast domain, including a loss found by the slow watchdog once the fast clock runs again.
- R9: Simultaneous event pulses are ranked: brownout first, then external pin, then watchdog. On any fast cycle with no event pulse and no new clock loss, `cause_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast clock; also clocks the control register and the cause record |
| clk_slow | input | 1 | Slow always-on clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pause_i | input | 1 | High while a low-power mode may stop the clocks; suspends detection |
| reg_wr_i | input | 1 | Control register write strobe, fast domain |
| reg_wdata_i | input | 8 | Control register write data; only bit 0 is kept |
| reg_rdata_o | output | 8 | Control register readback |
| bod_evt_i | input | 1 | One-cycle pulse: brownout reset raised |
| ext_evt_i | input | 1 | One-cycle pulse: external pin reset raised |
| wdt_evt_i | input | 1 | One-cycle pulse: watchdog reset raised |
| rst_req_o | output | 1 | Sticky clock-loss reset request |
| cause_o | output | 2 | Last reset cause code |

## Verification
The bound checker covers the fast-domain rules on every fast clock edge. These are the control-bit write, the stickiness of the reset request, the cause code written by each event pulse under its priority, and the stability of the cause record when nothing happens. The timing windows of detection cannot be checked this way. Those are the lower and upper bounds after a clock stops, the silence while disabled or paused, and the absence of a false request after a resume. These only show in the bench scenarios, which stop and restart each clock at known times and sample the request at computed instants. The same applies to the late recording of a slow-domain loss once the fast clock returns.

// File: rtl/clkloss_pkg.sv
// Shared definitions for the mutual clock-loss monitor.
// Assumes: nothing beyond standard SystemVerilog.
package clkloss_pkg;

    // Width of the software control register.
    localparam int CTRL_W = 8;

    // Reset-cause codes held in the 2-bit record.
    typedef enum logic [1:0] {
        CAUSE_POR     = 2'b00,
        CAUSE_PIN     = 2'b01,
        CAUSE_WDOG    = 2'b10,
        CAUSE_CLKLOSS = 2'b11
    } cause_e;

endpackage

// File: rtl/clkloss_sync2.sv
// Two-flop synchronizer bank for signals entering a clock domain.
// Assumes: each bit is quasi-static or a level whose glitches are tolerable;
// no multi-bit coherency is promised across bits.
module clkloss_sync2 #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Capture then stabilise the incoming bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= {W{RST_VAL}};
            stab_q <= {W{RST_VAL}};
        end else begin
            meta_q <= d_i;
            stab_q <= meta_q;
        end
    end

    assign q_o = stab_q;

endmodule

// File: rtl/clkloss_beacon.sv
// Fast-domain beacon: a flag that flips every HALF fast cycles, giving the
// slow domain evidence that the fast clock is alive.
// Assumes: HALF >= 2 and HALF fast cycles exceed one slow period, so the
// slow domain never aliases the beacon.
module clkloss_beacon #(
    parameter int HALF = 1536
) (
    input  logic clk,
    input  logic rst_n,
    output logic flag_o
);

    localparam int DW = $clog2(HALF);

    logic [DW-1:0] div_q;
    logic          flag_q;

    // Divide the clock and flip the flag at each wrap.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            flag_q <= 1'b0;
        end else if (div_q == DW'(HALF - 1)) begin
            div_q  <= '0;
            flag_q <= ~flag_q;
        end else begin
            div_q  <= div_q + 1'b1;
        end
    end

    assign flag_o = flag_q;

endmodule

// File: rtl/clkloss_activity_watch.sv
// Activity watchdog for a peer clock, run in the local clock domain.
// ANY_CHANGE=0 treats a rising edge of the synchronized peer level as proof
// of life; ANY_CHANGE=1 treats either transition (toggle beacon) as proof.
// The counter and settle window stay cleared while run_i is low; the loss
// flag is sticky until rst_n.
// Assumes: peer_i is already synchronized to clk.
module clkloss_activity_watch #(
    parameter int LIMIT      = 16000,
    parameter int SETTLE     = 4,
    parameter bit ANY_CHANGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic peer_i,
    output logic loss_o
);

    localparam int CW = $clog2(LIMIT + 1);
    localparam int SW = $clog2(SETTLE + 1);

    logic          peer_d;
    logic          alive;
    logic          live;
    logic [SW-1:0] settle_q;
    logic [CW-1:0] cnt_q;
    logic          loss_q;

    // Remember the previous peer level for edge detection.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) peer_d <= 1'b0;
        else        peer_d <= peer_i;
    end

    // Pick the proof-of-life rule for this instance.
    generate
        if (ANY_CHANGE) begin : g_toggle
            assign alive = peer_i ^ peer_d;
        end else begin : g_rise
            assign alive = peer_i & ~peer_d;
        end
    endgenerate

    // Hold the watchdog quiet for SETTLE cycles after each start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       settle_q <= '0;
        else if (!run_i)                  settle_q <= '0;
        else if (settle_q != SW'(SETTLE)) settle_q <= settle_q + 1'b1;
    end

    assign live = run_i && (settle_q == SW'(SETTLE));

    // Count local cycles since the peer last showed activity.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (!live || alive)       cnt_q <= '0;
        else if (cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
    end

    // Latch a loss once the count reaches its limit.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              loss_q <= 1'b0;
        else if (live && cnt_q == CW'(LIMIT))    loss_q <= 1'b1;
    end

    assign loss_o = loss_q;

endmodule

// File: rtl/clkloss_cause_rec.sv
// Reset-cause record in the fast domain. Only rst_n (power-on) clears it;
// every other reset source overwrites it on its event cycle.
// Priority: brownout, then new clock loss, then external pin, then watchdog.
// Assumes: event inputs are one-cycle pulses; loss_i is a sticky level.
module clkloss_cause_rec
    import clkloss_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   bod_i,
    input  logic   ext_i,
    input  logic   wdt_i,
    input  logic   loss_i,
    output cause_e cause_o
);

    logic   loss_d;
    logic   loss_new;
    cause_e cause_q;

    // Track the loss level so only its first cycle counts as an event.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) loss_d <= 1'b0;
        else        loss_d <= loss_i;
    end

    assign loss_new = loss_i & ~loss_d;

    // Overwrite the cause with the highest-ranked event of this cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cause_q <= CAUSE_POR;
        else if (bod_i)    cause_q <= CAUSE_POR;
        else if (loss_new) cause_q <= CAUSE_CLKLOSS;
        else if (ext_i)    cause_q <= CAUSE_PIN;
        else if (wdt_i)    cause_q <= CAUSE_WDOG;
    end

    assign cause_o = cause_q;

endmodule

// File: rtl/clkloss_monitor.sv
// Mutual clock-loss monitor: fast and slow clocks watch each other and a
// sticky reset request is raised if either stops while monitoring runs.
// Holds the software enable bit and the reset-cause record.
// Assumes: por_n is asynchronous and active-low; register access and event
// pulses are in the fast domain; after a reset the fast clock input is fed
// from a running source, so a slow-domain loss is recorded once it returns.
module clkloss_monitor
    import clkloss_pkg::*;
#(
    parameter int FAST_LIMIT = 16000,
    parameter int SLOW_LIMIT = 8,
    parameter int SETTLE     = 4,
    parameter int TOG_HALF   = 1536
) (
    input  logic              clk_fast,
    input  logic              clk_slow,
    input  logic              por_n,
    input  logic              pause_i,
    input  logic              reg_wr_i,
    input  logic [CTRL_W-1:0] reg_wdata_i,
    output logic [CTRL_W-1:0] reg_rdata_o,
    input  logic              bod_evt_i,
    input  logic              ext_evt_i,
    input  logic              wdt_evt_i,
    output logic              rst_req_o,
    output logic [1:0]        cause_o
);

    logic       en_q;
    logic       pause_f;
    logic       run_f;
    logic [1:0] ctl_s;
    logic       run_s;
    logic       slow_lvl_f;
    logic       beacon_f;
    logic       beacon_s;
    logic       loss_f;
    logic       loss_s;
    logic       loss_s_f;
    cause_e     cause_w;
    logic       unused_wdata;

    assign unused_wdata = ^reg_wdata_i[CTRL_W-1:1];

    // Software enable bit, cleared by power-on reset.
    always_ff @(posedge clk_fast or negedge por_n) begin
        if (!por_n)        en_q <= 1'b0;
        else if (reg_wr_i) en_q <= reg_wdata_i[0];
    end

    assign reg_rdata_o = {{(CTRL_W-1){1'b0}}, en_q};

    // Pause into the fast domain.
    clkloss_sync2 #(.W(1)) u_sync_pause_f (
        .clk(clk_fast), .rst_n(por_n), .d_i(pause_i), .q_o(pause_f)
    );

    assign run_f = en_q & ~pause_f;

    // Enable and pause into the slow domain, so pause acts even if the
    // fast clock halts.
    clkloss_sync2 #(.W(2)) u_sync_ctl_s (
        .clk(clk_slow), .rst_n(por_n), .d_i({en_q, pause_i}), .q_o(ctl_s)
    );

    assign run_s = ctl_s[1] & ~ctl_s[0];

    // Slow clock level sampled in the fast domain.
    clkloss_sync2 #(.W(1)) u_sync_slow_lvl (
        .clk(clk_fast), .rst_n(por_n), .d_i(clk_slow), .q_o(slow_lvl_f)
    );

    // Fast-side beacon and its crossing into the slow domain.
    clkloss_beacon #(.HALF(TOG_HALF)) u_beacon (
        .clk(clk_fast), .rst_n(por_n), .flag_o(beacon_f)
    );

    clkloss_sync2 #(.W(1)) u_sync_beacon (
        .clk(clk_slow), .rst_n(por_n), .d_i(beacon_f), .q_o(beacon_s)
    );

    // Fast domain watches the slow clock edges.
    clkloss_activity_watch #(
        .LIMIT(FAST_LIMIT), .SETTLE(SETTLE), .ANY_CHANGE(1'b0)
    ) u_watch_fast (
        .clk(clk_fast), .rst_n(por_n), .run_i(run_f),
        .peer_i(slow_lvl_f), .loss_o(loss_f)
    );

    // Slow domain watches the fast beacon.
    clkloss_activity_watch #(
        .LIMIT(SLOW_LIMIT), .SETTLE(SETTLE), .ANY_CHANGE(1'b1)
    ) u_watch_slow (
        .clk(clk_slow), .rst_n(por_n), .run_i(run_s),
        .peer_i(beacon_s), .loss_o(loss_s)
    );

    assign rst_req_o = loss_f | loss_s;

    // Slow-domain loss into the fast domain for cause recording.
    clkloss_sync2 #(.W(1)) u_sync_loss_s (
        .clk(clk_fast), .rst_n(por_n), .d_i(loss_s), .q_o(loss_s_f)
    );

    clkloss_cause_rec u_cause (
        .clk(clk_fast), .rst_n(por_n),
        .bod_i(bod_evt_i), .ext_i(ext_evt_i), .wdt_i(wdt_evt_i),
        .loss_i(loss_f | loss_s_f), .cause_o(cause_w)
    );

    assign cause_o = cause_w;

endmodule

// File: rtl/clkloss_monitor_chk.sv
// Checker for the fast-domain port behaviour of clkloss_monitor.
// Assumes: it is bound to every instance of the top module.
module clkloss_monitor_chk (
    input logic       clk_fast,
    input logic       por_n,
    input logic       reg_wr_i,
    input logic [7:0] reg_wdata_i,
    input logic [7:0] reg_rdata_o,
    input logic       bod_evt_i,
    input logic       ext_evt_i,
    input logic       wdt_evt_i,
    input logic       rst_req_o,
    input logic [1:0] cause_o
);

    // R1: a write sets the enable bit; reserved bits read zero.
    p_ctrl_rw_r1: assert property (@(posedge clk_fast) disable iff (!por_n)
        reg_wr_i |=> reg_rdata_o == {7'b0, $past(reg_wdata_i[0])});

    // R5: the request never drops without power-on reset.
    p_req_sticky_r5: assert property (@(posedge clk_fast) disable iff (!por_n)
        rst_req_o |=> rst_req_o);

    // R8: brownout records the power-on code.
    p_cause_bod_r8: assert property (@(posedge clk_fast) disable iff (!por_n)
        bod_evt_i |=> cause_o == 2'b00);

    // R9: external pin outranks watchdog.
    p_cause_ext_r9: assert property (@(posedge clk_fast) disable iff (!por_n)
        (ext_evt_i && !bod_evt_i && !rst_req_o) |=> cause_o == 2'b01);

    // R8: watchdog alone records its code.
    p_cause_wdt_r8: assert property (@(posedge clk_fast) disable iff (!por_n)
        (wdt_evt_i && !ext_evt_i && !bod_evt_i && !rst_req_o) |=> cause_o == 2'b10);

    // R9: no event and no loss keeps the record.
    p_cause_hold_r9: assert property (@(posedge clk_fast) disable iff (!por_n)
        (!bod_evt_i && !ext_evt_i && !wdt_evt_i && !rst_req_o) |=> $stable(cause_o));

endmodule

bind clkloss_monitor clkloss_monitor_chk u_chk (
    .clk_fast   (clk_fast),
    .por_n      (por_n),
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .bod_evt_i  (bod_evt_i),
    .ext_evt_i  (ext_evt_i),
    .wdt_evt_i  (wdt_evt_i),
    .rst_req_o  (rst_req_o),
    .cause_o    (cause_o)
);

// File: tb/clkloss_monitor_tb.sv
// Bench for clkloss_monitor: small limits, gated clocks, computed windows.
module clkloss_monitor_tb;

    localparam int FL = 64;
    localparam int SL = 8;

    logic       clk_fast = 1'b0;
    logic       clk_slow = 1'b0;
    logic       fast_run = 1'b1;
    logic       slow_run = 1'b1;
    logic       por_n = 1'b0;
    logic       pause_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic       bod_evt_i = 1'b0;
    logic       ext_evt_i = 1'b0;
    logic       wdt_evt_i = 1'b0;
    logic       rst_req_o;
    logic [1:0] cause_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // 100 MHz fast clock, gateable.
    always begin
        #5;
        if (fast_run) clk_fast = ~clk_fast;
    end

    // Slow clock at 1/16 of the fast rate, offset from fast edges.
    initial begin
        #3;
        forever begin
            #80;
            if (slow_run) clk_slow = ~clk_slow;
        end
    end

    clkloss_monitor #(
        .FAST_LIMIT(FL), .SLOW_LIMIT(SL), .SETTLE(4), .TOG_HALF(24)
    ) u_dut (
        .clk_fast(clk_fast), .clk_slow(clk_slow), .por_n(por_n),
        .pause_i(pause_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .bod_evt_i(bod_evt_i),
        .ext_evt_i(ext_evt_i), .wdt_evt_i(wdt_evt_i),
        .rst_req_o(rst_req_o), .cause_o(cause_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk_fast);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk_fast);
        reg_wr_i = 1'b1; reg_wdata_i = v;
        @(negedge clk_fast);
        reg_wr_i = 1'b0;
    endtask

    task automatic pulse(input logic b, input logic e, input logic w);
        @(negedge clk_fast);
        bod_evt_i = b; ext_evt_i = e; wdt_evt_i = w;
        @(negedge clk_fast);
        bod_evt_i = 1'b0; ext_evt_i = 1'b0; wdt_evt_i = 1'b0;
    endtask

    task automatic power_on();
        por_n = 1'b0;
        #33;
        check("R8 por cause", cause_o, 0);
        check("R5 por clears request", rst_req_o, 0);
        @(negedge clk_fast);
        por_n = 1'b1;
    endtask

    initial begin
        logic [1:0] exp_cause;
        #1_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] exp_cause;
        #27;
        check("R1 reset rdata", reg_rdata_o, 0);
        check("R8 reset cause", cause_o, 0);
        @(negedge clk_fast);
        por_n = 1'b1;
        ticks(2);

        // R1: sweep all write values; reserved bits must read zero.
        for (int v = 0; v < 256; v++) begin
            wr(8'(v));
            check("R1 ctrl readback", reg_rdata_o, v & 1);
        end
        @(negedge clk_fast);
        reg_wdata_i = 8'hFF;
        ticks(2);
        check("R1 no write without strobe", reg_rdata_o, 1);

        // R9: sweep event combinations; the bench models the priority.
        exp_cause = 2'b00;
        for (int pass = 0; pass < 2; pass++) begin
            for (int k = 0; k < 8; k++) begin
                int c = (pass == 0) ? k : 7 - k;
                logic b = c[2], e = c[1], w = c[0];
                pulse(b, e, w);
                if (b)      exp_cause = 2'b00;
                else if (e) exp_cause = 2'b01;
                else if (w) exp_cause = 2'b10;
                check("R9 event priority", cause_o, exp_cause);
            end
        end
        pulse(1'b0, 1'b0, 1'b1);
        ticks(40);
        check("R9 cause held without event", cause_o, 2);

        // R2: enabled, both clocks alive.
        wr(8'h01);
        ticks(600);
        check("R2 no request while clocks run", rst_req_o, 0);

        // R3: stop the slow clock.
        @(negedge clk_slow);
        slow_run = 1'b0;
        #400;
        check("R3 not before limit", rst_req_o, 0);
        #250;
        check("R3 request in window", rst_req_o, 1);
        check("R9 cause after loss event", cause_o, 3);
        check("R8 clock-loss code", cause_o, 3);
        slow_run = 1'b1;
        wr(8'h00);
        ticks(100);
        check("R5 request sticky", rst_req_o, 1);
        power_on();

        // R4: stop the fast clock.
        wr(8'h01);
        ticks(200);
        check("R2 no request before fast stop", rst_req_o, 0);
        @(negedge clk_fast);
        fast_run = 1'b0;
        #320;
        check("R4 not at two slow cycles", rst_req_o, 0);
        #1600;
        check("R4 request within limit", rst_req_o, 1);
        fast_run = 1'b1;
        ticks(10);
        check("R8 slow-side loss recorded", cause_o, 3);
        check("R5 sticky after fast return", rst_req_o, 1);
        power_on();

        // R6: disabled, stop each clock.
        ticks(4);
        check("R6 enable off after por", reg_rdata_o, 0);
        slow_run = 1'b0;
        #2000;
        check("R6 slow stop ignored", rst_req_o, 0);
        slow_run = 1'b1;
        ticks(20);
        fast_run = 1'b0;
        #3000;
        check("R6 fast stop ignored", rst_req_o, 0);
        fast_run = 1'b1;
        ticks(100);
        check("R6 still quiet", rst_req_o, 0);

        // R7: pause suspends detection.
        wr(8'h01);
        ticks(50);
        pause_i = 1'b1;
        ticks(100);
        slow_run = 1'b0;
        #2000;
        check("R7 slow stop while paused", rst_req_o, 0);
        slow_run = 1'b1;
        ticks(50);
        fast_run = 1'b0;
        #3000;
        check("R7 fast stop while paused", rst_req_o, 0);
        fast_run = 1'b1;
        ticks(30);
        pause_i = 1'b0;
        ticks(800);
        check("R7 no false request on resume", rst_req_o, 0);
        @(negedge clk_slow);
        slow_run = 1'b0;
        #650;
        check("R7 detection resumes", rst_req_o, 1);
        slow_run = 1'b1;
        power_on();
        check("R8 por after loss", cause_o, 0);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule